// File: doc/BRIEF.md
# Set/Way Data-Cache Flush Sequencer

This block walks a set-associative level-1 data cache by set and way and emits one clean-and-invalidate operation word for every line position. A consumer takes each word over a valid/ready handshake. When the last word has been taken, the block makes one register write to a level-2 cache controller, which cleans and invalidates every level-2 way. A one-cycle `done` pulse then ends the flush.

The cache geometry comes from a 32-bit size-identification word. The block decodes three fields from it: the line-size code, the number of ways minus one and the number of sets minus one. From these it derives the bit position of the set index and the bit position of the way number in each operation word. The geometry word, the level-2 base address and the level-2 way count are all sampled at `start`. If the data cache is reported off when `start` is sampled, the whole flush is skipped.

The control is a four-state machine:
- `ST_IDLE`: waits for `start`. On `start` it goes to `ST_SWEEP` when the cache is on, or to `ST_FINISH` when it is off.
- `ST_SWEEP`: presents operation words. It goes to `ST_L2WR` when the last word is acknowledged.
- `ST_L2WR`: presents the level-2 write. It goes to `ST_FINISH` when the write is acknowledged.
- `ST_FINISH`: pulses `done` and returns to `ST_IDLE`.

Top module: `swf_flush_seq`

## Requirements
- R1: Geometry decode uses three fields of `geom_word`. Bits [2:0] are the line code L, and the set-index position is L+4. Bits [12:3] hold A-1, where A is the associativity (a power of two), and the way position is 32-log2(A). Bits [27:13] hold S-1, where S is the number of sets.
- R2: Each operation word equals (set << (L+4)) | (way << (32-log2(A))), truncated to 32 bits. When A=1 the way term is zero.
- R3: Operation words come out in this order: set from S-1 down to 0 in the outer loop, and for each set the way from A-1 down to 0. Exactly S*A words are emitted per flush.
- R4: While `op_valid` is high and `op_ready` is low, `op_valid` stays high and `op_word` holds its value into the next cycle.
- R5: After the last operation word is accepted, one write is presented with `reg_addr` = `l2_base` + 0x7FC and `reg_data` = (1 << `l2_way_cnt`) - 1, for way counts 0 to 32. `op_valid` and `reg_valid` are never high together.
- R6: While `reg_valid` is high and `reg_ready` is low, the write stays valid and its address and data hold their values.
- R7: `done` is high for exactly one cycle, in the cycle after the write is accepted. `busy` is high from the cycle after `start` until `done`.
- R8: If `dc_enabled` is low when `start` is sampled, no operation word and no write are issued, and `done` pulses in the cycle after `start`.
- R9: `start` has no effect while a flush is in progress. The word sequence continues unchanged, and a single write and a single `done` follow.
- R10: `geom_word`, `l2_base`, `l2_way_cnt` and `dc_enabled` are sampled only at the accepted `start`. Changing them during a flush leaves the words, the write and `done` unchanged.
- R11: After reset, `op_valid`, `reg_valid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Flush request, sampled when idle |
| dc_enabled | input | 1 | Level-1 data cache is on |
| geom_word | input | 32 | Cache size identification word |
| l2_base | input | 32 | Level-2 controller base address |
| l2_way_cnt | input | L2_CNT_W (6) | Number of level-2 ways |
| op_valid | output | 1 | Operation word valid |
| op_word | output | 32 | Set/way clean-invalidate word |
| op_ready | input | 1 | Consumer accepts operation word |
| reg_valid | output | 1 | Level-2 register write valid |
| reg_addr | output | 32 | Level-2 register write address |
| reg_data | output | 32 | Level-2 way mask |
| reg_ready | input | 1 | Level-2 write accepted |
| busy | output | 1 | Flush in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The sweep is tried with four geometries: 4 ways by 8 sets, a direct-mapped cache, 8 ways by 16 sets, and 2 ways with one set. Together they separate a wrong set shift from a wrong way shift, show whether the 32-bit way shift for A=1 drops the way term, and show whether the wrap from way 0 to the next set happens at the right point. The consumer runs either always ready or with pseudo-random stalls, so the hold rules and the acknowledge counting are exercised under back-pressure. Level-2 way counts of 8, 0, 32 and 16 cover an empty mask, a full mask and two ordinary masks. One run pulses `start` and changes every configuration input in the middle of the flush, to show that the values captured at `start` are kept. A run with the cache off shows the immediate completion.

// File: rtl/swf_pkg.sv
package swf_pkg;
    localparam int WORD_W   = 32;
    localparam int CODE_W   = 3;
    localparam int WAYF_W   = 10;
    localparam int SETF_W   = 15;
    localparam int WAYF_LSB = CODE_W;
    localparam int SETF_LSB = CODE_W + WAYF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SWEEP,
        ST_L2WR,
        ST_FINISH
    } swf_state_e;

    typedef struct packed {
        logic [4:0]        idx_sh;
        logic [5:0]        way_sh;
        logic [SETF_W-1:0] set_top;
        logic [WAYF_W-1:0] way_top;
    } swf_geom_t;
endpackage

// File: rtl/swf_geom_decode.sv
module swf_geom_decode
    import swf_pkg::*;
(
    input  logic [WORD_W-1:0] id_word,
    output swf_geom_t         geom
);
    localparam int ASSOC_W = WAYF_W + 1;

    function automatic logic [3:0] top_bit(input logic [ASSOC_W-1:0] v);
        logic [3:0] r;
        r = '0;
        for (int i = 0; i < ASSOC_W; i++) begin
            if (v[i]) r = 4'(i);
        end
        return r;
    endfunction

    logic [CODE_W-1:0]  line_code;
    logic [ASSOC_W-1:0] assoc;
    logic [3:0]         assoc_log2;

    always_comb begin
        line_code      = id_word[CODE_W-1:0];
        assoc          = {1'b0, id_word[WAYF_LSB +: WAYF_W]} + ASSOC_W'(1);
        assoc_log2     = top_bit(assoc);
        geom.idx_sh    = 5'(line_code) + 5'd4;
        geom.way_sh    = 6'd32 - 6'(assoc_log2);
        geom.set_top   = id_word[SETF_LSB +: SETF_W];
        geom.way_top   = id_word[WAYF_LSB +: WAYF_W];
    end
endmodule

// File: rtl/swf_sweep_ctr.sv
module swf_sweep_ctr #(
    parameter int SET_W = 15,
    parameter int WAY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [SET_W-1:0] set_top,
    input  logic [WAY_W-1:0] way_top,
    output logic [SET_W-1:0] set_idx,
    output logic [WAY_W-1:0] way_idx,
    output logic             last
);
    logic [WAY_W-1:0] way_max_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_idx   <= '0;
            way_idx   <= '0;
            way_max_q <= '0;
        end else if (load) begin
            set_idx   <= set_top;
            way_idx   <= way_top;
            way_max_q <= way_top;
        end else if (step) begin
            if (way_idx == '0) begin
                way_idx <= way_max_q;
                set_idx <= set_idx - SET_W'(1);
            end else begin
                way_idx <= way_idx - WAY_W'(1);
            end
        end
    end

    assign last = (set_idx == '0) && (way_idx == '0);

    // R3: way 0 of a set hands over to the top way of the next lower set
    p_set_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && way_idx == '0 && set_idx != '0
        |=> way_idx == way_max_q && set_idx == $past(set_idx) - SET_W'(1));

    // R3: inside a set the way only counts down by one
    p_way_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && way_idx != '0
        |=> way_idx == $past(way_idx) - WAY_W'(1) && $stable(set_idx));
endmodule

// File: rtl/swf_l2_req.sv
module swf_l2_req #(
    parameter int          WORD_W   = 32,
    parameter int          CNT_W    = 6,
    parameter logic [31:0] REG_OFS  = 32'h7FC
) (
    input  logic [WORD_W-1:0] base,
    input  logic [CNT_W-1:0]  ways,
    output logic [WORD_W-1:0] addr,
    output logic [WORD_W-1:0] mask
);
    logic [WORD_W:0] wide;

    always_comb begin
        wide = ((WORD_W+1)'(1) << ways) - (WORD_W+1)'(1);
        mask = wide[WORD_W-1:0];
        addr = base + WORD_W'(REG_OFS);
    end
endmodule

// File: rtl/swf_flush_seq.sv
module swf_flush_seq
    import swf_pkg::*;
#(
    parameter int          L2_CNT_W   = 6,
    parameter logic [31:0] L2_REG_OFS = 32'h7FC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                dc_enabled,
    input  logic [WORD_W-1:0]   geom_word,
    input  logic [WORD_W-1:0]   l2_base,
    input  logic [L2_CNT_W-1:0] l2_way_cnt,
    output logic                op_valid,
    output logic [WORD_W-1:0]   op_word,
    input  logic                op_ready,
    output logic                reg_valid,
    output logic [WORD_W-1:0]   reg_addr,
    output logic [WORD_W-1:0]   reg_data,
    input  logic                reg_ready,
    output logic                busy,
    output logic                done
);
    swf_state_e state_q, state_d;
    swf_geom_t  geom_d, geom_q;
    logic [WORD_W-1:0]   base_q;
    logic [L2_CNT_W-1:0] ways_q;
    logic [SETF_W-1:0]   set_idx;
    logic [WAYF_W-1:0]   way_idx;
    logic                last_op;
    logic                accept;
    logic                step;

    swf_geom_decode u_dec (
        .id_word (geom_word),
        .geom    (geom_d)
    );

    assign accept = (state_q == ST_IDLE) && start;
    assign step   = (state_q == ST_SWEEP) && op_ready;

    swf_sweep_ctr #(.SET_W(SETF_W), .WAY_W(WAYF_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (step),
        .set_top (geom_d.set_top),
        .way_top (geom_d.way_top),
        .set_idx (set_idx),
        .way_idx (way_idx),
        .last    (last_op)
    );

    swf_l2_req #(.WORD_W(WORD_W), .CNT_W(L2_CNT_W), .REG_OFS(L2_REG_OFS)) u_l2 (
        .base (base_q),
        .ways (ways_q),
        .addr (reg_addr),
        .mask (reg_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            geom_q  <= '0;
            base_q  <= '0;
            ways_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                geom_q <= geom_d;
                base_q <= l2_base;
                ways_q <= l2_way_cnt;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = dc_enabled ? ST_SWEEP : ST_FINISH;
            ST_SWEEP:  if (op_ready && last_op) state_d = ST_L2WR;
            ST_L2WR:   if (reg_ready) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        op_valid  = 1'b0;
        reg_valid = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        op_word   = (WORD_W'(set_idx) << geom_q.idx_sh) |
                    (WORD_W'(way_idx) << geom_q.way_sh);
        unique case (state_q)
            ST_IDLE:   busy      = 1'b0;
            ST_SWEEP:  op_valid  = 1'b1;
            ST_L2WR:   reg_valid = 1'b1;
            ST_FINISH: done      = 1'b1;
        endcase
    end

    // R4: an unaccepted operation word is held
    p_op_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_word));

    // R6: an unaccepted register write is held
    p_reg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) && $stable(reg_data));

    // R5: the two request channels never overlap
    p_one_channel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && reg_valid));

    // R5: acceptance of the final word leads straight to the level-2 write
    p_last_to_l2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && last_op |=> reg_valid);

    // R7: done is a single-cycle pulse following the accepted write
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    p_write_to_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && reg_ready |=> done);

    // R8: a flush requested with the cache off completes at once
    p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && !dc_enabled |=> done && !op_valid && !reg_valid);

    // R9: a start while busy does not reload the sweep
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready && start |=> $stable(op_word));
endmodule

// File: tb/swf_flush_seq_bench.sv
`timescale 1ns/1ps
module swf_flush_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dc_enabled = 1'b0;
    logic [31:0] geom_word = '0;
    logic [31:0] l2_base = '0;
    logic [5:0]  l2_way_cnt = '0;
    logic        op_valid, reg_valid, busy, done;
    logic [31:0] op_word, reg_addr, reg_data;
    logic        op_ready = 1'b0;
    logic        reg_ready = 1'b0;

    always #2.5 clk = ~clk;

    swf_flush_seq u_swf_flush_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dc_enabled(dc_enabled),
        .geom_word(geom_word), .l2_base(l2_base), .l2_way_cnt(l2_way_cnt),
        .op_valid(op_valid), .op_word(op_word), .op_ready(op_ready),
        .reg_valid(reg_valid), .reg_addr(reg_addr), .reg_data(reg_data),
        .reg_ready(reg_ready), .busy(busy), .done(done)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    logic [31:0] exp_addr, exp_data;
    int op_seen, wr_seen, done_seen, wr_cyc, done_cyc;
    bit stall = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit prev_op_wait = 0, prev_reg_wait = 0, prev_done = 0;
    logic [31:0] prev_word, prev_addr, prev_data;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: drives ready, pops the scoreboard on every accepted item
    always @(negedge clk) begin
        if (!rst_n) begin
            op_ready  = 1'b0;
            reg_ready = 1'b0;
        end else begin
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op_ready  = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
            reg_ready = stall ? (lfsr[1] & lfsr[5]) : 1'b1;
            if (prev_op_wait)
                chk(op_valid && op_word == prev_word, "R4", "held op word", op_word, prev_word);
            if (prev_reg_wait)
                chk(reg_valid && reg_addr == prev_addr && reg_data == prev_data,
                    "R6", "held write", reg_data, prev_data);
            chk(!(op_valid && reg_valid), "R5", "channels overlap", {31'b0, reg_valid}, 32'd0);
            if (op_valid && op_ready) begin
                op_seen++;
                if (exp_q.size() == 0)
                    chk(1'b0, "R3", "extra op word", op_word, 32'hx);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(op_word == e, "R2 R3", "op word", op_word, e);
                end
            end
            if (reg_valid && reg_ready) begin
                wr_seen++;
                wr_cyc = cyc;
                chk(reg_addr == exp_addr, "R5", "l2 address", reg_addr, exp_addr);
                chk(reg_data == exp_data, "R5", "l2 mask", reg_data, exp_data);
            end
            if (done) begin
                done_seen++;
                done_cyc = cyc;
                if (prev_done) chk(1'b0, "R7", "done longer than one cycle", 32'd1, 32'd0);
            end
            prev_op_wait  = op_valid && !op_ready;
            prev_word     = op_word;
            prev_reg_wait = reg_valid && !reg_ready;
            prev_addr     = reg_addr;
            prev_data     = reg_data;
            prev_done     = done;
        end
    end

    // driver: pushes the expected words and runs one flush
    task automatic run_flush(input logic [31:0] gw, input bit en, input logic [31:0] base,
                             input int ways, input bit st, input bit disturb);
        int code, af, sf, lg, n_exp, s_cyc;
        logic [63:0] wide;
        code = int'(gw[2:0]);
        af   = int'(gw[12:3]);
        sf   = int'(gw[27:13]);
        lg   = 0;
        while ((1 << lg) < af + 1) lg++;
        n_exp = 0;
        if (en) begin
            for (int s = sf; s >= 0; s--) begin
                for (int w = af; w >= 0; w--) begin
                    logic [63:0] t;
                    t = (64'(s) << (code + 4)) | (64'(w) << (32 - lg));
                    exp_q.push_back(t[31:0]);
                    n_exp++;
                end
            end
        end
        wide     = (64'd1 << ways) - 64'd1;
        exp_data = wide[31:0];
        exp_addr = base + 32'h7FC;
        stall    = st;
        op_seen = 0; wr_seen = 0; done_seen = 0; wr_cyc = 0; done_cyc = 0;

        @(negedge clk); #0.1;
        geom_word = gw; dc_enabled = en; l2_base = base; l2_way_cnt = 6'(ways);
        start = 1'b1; s_cyc = cyc;
        @(negedge clk); #0.1;
        start = 1'b0;
        chk(busy, "R7", "busy after start", {31'b0, busy}, 32'd1);
        if (disturb) begin
            repeat (5) @(negedge clk);
            #0.1;
            start = 1'b1; geom_word = 32'h0FFF_FFFF; dc_enabled = 1'b0;
            l2_base = 32'hDEAD_0000; l2_way_cnt = 6'd3;  // R9 R10
            @(negedge clk); #0.1;
            start = 1'b0;
        end
        for (int k = 0; k < 40000 && done_seen == 0; k++) begin
            @(negedge clk); #0.1;
        end
        chk(done_seen == 1, "R7", "done count", done_seen, 1);
        chk(exp_q.size() == 0, "R3", "words left over", exp_q.size(), 0);
        chk(op_seen == n_exp, "R3", "word count", op_seen, n_exp);
        if (en) begin
            chk(wr_seen == 1, "R5", "write count", wr_seen, 1);
            chk(done_cyc == wr_cyc + 1, "R7", "done timing", done_cyc, wr_cyc + 1);
        end else begin
            chk(wr_seen == 0, "R8", "write when off", wr_seen, 0);
            chk(op_seen == 0, "R8", "words when off", op_seen, 0);
            chk(done_cyc == s_cyc + 1, "R8", "done timing when off", done_cyc, s_cyc + 1);
        end
        repeat (3) @(negedge clk);
        #0.1;
        chk(!busy && done_seen == 1 && wr_seen == (en ? 1 : 0), "R9",
            "activity after completion", done_seen, 1);
        exp_q.delete();
    endtask

    function automatic logic [31:0] gw_make(input int code, input int assoc_m1, input int sets_m1);
        return (32'(sets_m1) << 13) | (32'(assoc_m1) << 3) | 32'(code);
    endfunction

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.1;
        chk(!op_valid && !reg_valid && !busy && !done, "R11", "reset outputs",
            {28'b0, op_valid, reg_valid, busy, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #0.1;
        chk(!op_valid && !reg_valid && !busy && !done, "R11", "idle after reset",
            {28'b0, op_valid, reg_valid, busy, done}, 32'd0);
        // R1 R2: 4 ways, 8 sets, line code 1
        run_flush(gw_make(1, 3, 7), 1'b1, 32'h1000_0000, 8, 1'b0, 1'b0);
        // R1 R2: direct mapped, way term vanishes; empty level-2 mask
        run_flush(gw_make(0, 0, 3), 1'b1, 32'h2000_0100, 0, 1'b1, 1'b0);
        // R9 R10: 8 ways, 16 sets, stalls, disturbed mid-run, full mask
        run_flush(gw_make(2, 7, 15), 1'b1, 32'h3000_0000, 32, 1'b1, 1'b1);
        // R3: one set, two ways
        run_flush(gw_make(3, 1, 0), 1'b1, 32'h4000_0800, 16, 1'b1, 1'b0);
        // R8: cache off
        run_flush(gw_make(1, 3, 7), 1'b0, 32'h5000_0000, 8, 1'b0, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule